// File: doc/BRIEF.md
# Four-Channel Byte Mailbox with Handshake Flags

This block lets a host processor and a management controller pass bytes to each other through up to four independent mailbox channels. Each channel holds an inbound byte word (host to controller), an outbound byte word (controller to host) and a status word. Two handshake flags in the status word record which side has unread data. The flag for inbound data is set by a host write and cleared by a controller read. The flag for outbound data is set by a controller write and cleared by a host read.

The controller reaches the mailbox through a 32-bit register bus. Its address is a word index, which is the byte offset divided by four, inside a 4 KB window. The host has a strobe for writing the inbound byte of each channel, a strobe for consuming the outbound byte, and a status-write strobe that the block ignores. Control words in the same register space turn channels on and arm their inbound interrupts. Each channel drives its own interrupt line, and one summary line reports whether any channel interrupt is pending. Reset clears every word and every interrupt, then loads a strap value into word 34.

Top module: `kcs_mbox`

## Requirements
- R1: After reset every register word reads zero except word 34, which reads the STRAP_VAL parameter. All channel interrupts and the summary interrupt are low.
- R2: The channel words sit at these word indices (inbound/outbound/status): channel 0 at 9/12/15, channel 1 at 10/13/16, channel 2 at 11/14/17, channel 3 at 69/70/71. In a status word, bit 0 is the outbound-full flag and bit 1 is the inbound-full flag. Every other in-range word is plain read/write storage.
- R3: A host inbound write stores the byte, zero-extended, in the inbound word and sets the inbound-full flag on the next clock edge.
- R4: A controller read of an inbound word returns its value and clears the inbound-full flag on the next edge. If the flag was set, the read also drops the channel interrupt.
- R5: A controller write to an outbound word stores the value, sets the outbound-full flag and presents the low byte on the host outbound port. A host outbound read clears the flag.
- R6: A host inbound write raises the channel interrupt on the next edge only when the channel is enabled and its interrupt enable is set. The enables for channels 0, 1 and 2 are bits 5, 6 and 7 of word 0. The enable for channel 3 is bit 0 of word 64. The interrupt enables for channels 0, 1 and 2 are bits 1, 2 and 3 of word 2, and for channel 3 it is bit 1 of word 64.
- R7: Channel 2 counts as enabled only when bit 7 of word 0 and bit 2 of word 4 are both set.
- R8: A host status-write strobe has no effect on the status word.
- R9: Reads of word indices at or above NUM_WORDS (default 72) return zero, and writes to them change nothing.
- R10: The summary interrupt is high exactly while at least one channel interrupt is pending.
- R11: When the controller and the host touch the same channel in one cycle, the controller access is applied first and the host access second. A host inbound write therefore wins over a clearing read, and a host outbound read wins over an outbound write.
- R12: A controller write to a status word stores the full word, flags included. The host status port shows its low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Controller write strobe |
| reg_rd_en | input | 1 | Controller read strobe (side effects on the clock edge) |
| reg_addr | input | AW | Controller word index |
| reg_wdata | input | DW | Controller write data |
| reg_rdata | output | DW | Controller read data (combinational from reg_addr) |
| host_in_wr | input | NUM_CH | Host inbound write strobes, one per channel |
| host_in_byte | input | NUM_CH*8 | Host inbound bytes, channel c at bits c*8+7:c*8 |
| host_out_rd | input | NUM_CH | Host outbound read strobes |
| host_stat_wr | input | NUM_CH | Host status-write strobes (ignored) |
| host_out_byte | output | NUM_CH*8 | Outbound byte of each channel |
| host_stat | output | NUM_CH*8 | Low byte of each status word |
| chan_irq | output | NUM_CH | Per-channel interrupt lines |
| summary_irq | output | 1 | OR of all pending channel interrupts |

## Verification
A wrong flag state appears on the host status port one clock edge after the access that caused it, because every flag and interrupt is registered. A lost or doubled update therefore shows up at the next sample. A wrong enable decode shows up as a channel interrupt that rises or stays low after a host inbound write, and the summary line mirrors it in the same cycle. Collision cycles are driven on purpose, because a reversed priority leaves exactly one flag or interrupt in the wrong state while the stored data still looks correct.

// File: rtl/kcs_mbox_pkg.sv
package kcs_mbox_pkg;

   localparam int CH_MAX   = 4;
   localparam int BYTE_W   = 8;

   // status bit positions decoded by the host side
   localparam int ST_OBF   = 0;
   localparam int ST_IBF   = 1;
   localparam int ST_CD    = 3;

   // control word indices
   localparam int W_HOSTCTL0 = 0;
   localparam int W_IRQCTL   = 2;
   localparam int W_HOSTCTL4 = 4;
   localparam int W_STRAP    = 34;
   localparam int W_CH3CTL   = 64;

   // enable / interrupt-enable bit positions
   localparam int EN_BASE    = 5;   // channels 0..2 in word 0
   localparam int IE_BASE    = 1;   // channels 0..2 in word 2
   localparam int EN3_EXTRA  = 2;   // second enable of channel 2 in word 4
   localparam int EN_CH3     = 0;   // channel 3 enable in word 64
   localparam int IE_CH3     = 1;   // channel 3 interrupt enable in word 64

   localparam int LAST_WORD  = 71;

   function automatic int in_word(input int ch);
      case (ch)
         0: return 9;
         1: return 10;
         2: return 11;
         default: return 69;
      endcase
   endfunction

   function automatic int out_word(input int ch);
      case (ch)
         0: return 12;
         1: return 13;
         2: return 14;
         default: return 70;
      endcase
   endfunction

   function automatic int stat_word(input int ch);
      case (ch)
         0: return 15;
         1: return 16;
         2: return 17;
         default: return 71;
      endcase
   endfunction

endpackage

// File: rtl/kcs_mbox_enmap.sv
module kcs_mbox_enmap
   import kcs_mbox_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DW     = 32
) (
   input  logic [DW-1:0]     hostctl0,
   input  logic [DW-1:0]     irqctl,
   input  logic [DW-1:0]     hostctl4,
   input  logic [DW-1:0]     ch3ctl,
   output logic [NUM_CH-1:0] irq_ok
);

   logic [NUM_CH-1:0] chan_on;
   logic [NUM_CH-1:0] chan_ie;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      if (c == 3) begin : g_far
         assign chan_on[c] = ch3ctl[EN_CH3];
         assign chan_ie[c] = ch3ctl[IE_CH3];
      end else if (c == 2) begin : g_dual
         assign chan_on[c] = hostctl0[EN_BASE + c] & hostctl4[EN3_EXTRA];
         assign chan_ie[c] = irqctl[IE_BASE + c];
      end else begin : g_near
         assign chan_on[c] = hostctl0[EN_BASE + c];
         assign chan_ie[c] = irqctl[IE_BASE + c];
      end
      assign irq_ok[c] = chan_on[c] & chan_ie[c];
   end

endmodule

// File: rtl/kcs_mbox_chan.sv
module kcs_mbox_chan
   import kcs_mbox_pkg::*;
#(
   parameter int CH = 0,
   parameter int AW = 10,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_idx,
   input  logic [DW-1:0] bus_wdata,
   input  logic          host_wr,
   input  logic [7:0]    host_wbyte,
   input  logic          host_rd,
   input  logic          host_stat_wr,
   input  logic          irq_ok,
   output logic          hit,
   output logic [DW-1:0] rdata,
   output logic [7:0]    out_byte,
   output logic [7:0]    stat_byte,
   output logic          irq_q
);

   localparam logic [AW-1:0] IN_IDX   = AW'(in_word(CH));
   localparam logic [AW-1:0] OUT_IDX  = AW'(out_word(CH));
   localparam logic [AW-1:0] STAT_IDX = AW'(stat_word(CH));

   logic [DW-1:0] in_q, out_q, stat_q;
   logic [DW-1:0] in_d, out_d, stat_d;
   logic          irq_d;
   logic          hit_in, hit_out, hit_stat;

   assign hit_in   = (bus_idx == IN_IDX);
   assign hit_out  = (bus_idx == OUT_IDX);
   assign hit_stat = (bus_idx == STAT_IDX);
   assign hit      = hit_in | hit_out | hit_stat;

   always_comb begin
      if (hit_in)        rdata = in_q;
      else if (hit_out)  rdata = out_q;
      else if (hit_stat) rdata = stat_q;
      else               rdata = '0;
   end

   // controller side applied first, host side second
   always_comb begin
      in_d   = in_q;
      out_d  = out_q;
      stat_d = stat_q;
      irq_d  = irq_q;
      if (bus_wr) begin
         if (hit_in) in_d = bus_wdata;
         if (hit_out) begin
            out_d          = bus_wdata;
            stat_d[ST_OBF] = 1'b1;
         end
         if (hit_stat) stat_d = bus_wdata;
      end
      if (bus_rd && hit_in) begin
         if (stat_q[ST_IBF]) irq_d = 1'b0;
         stat_d[ST_IBF] = 1'b0;
      end
      if (host_wr) begin
         in_d           = DW'(host_wbyte);
         stat_d[ST_IBF] = 1'b1;
         if (irq_ok) irq_d = 1'b1;
      end
      if (host_rd) stat_d[ST_OBF] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q   <= '0;
         out_q  <= '0;
         stat_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         in_q   <= in_d;
         out_q  <= out_d;
         stat_q <= stat_d;
         irq_q  <= irq_d;
      end
   end

   assign out_byte  = out_q[7:0];
   assign stat_byte = stat_q[7:0];

   assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> stat_q[ST_IBF]);

   assert_ibf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_in && !host_wr) |=> !stat_q[ST_IBF]);

   assert_obf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_out && !host_rd) |=> stat_q[ST_OBF]);

   assert_host_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd |=> !stat_q[ST_OBF]);

   assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(irq_ok && host_wr));

   assert_stat_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_stat_wr && !host_wr && !host_rd && !(bus_wr && (hit_out || hit_stat))
       && !(bus_rd && hit_in)) |=> $stable(stat_q));

endmodule

// File: rtl/kcs_mbox_irqor.sv
module kcs_mbox_irqor #(
   parameter int NUM_CH = 4
) (
   input  logic [NUM_CH-1:0] pend,
   output logic              any_pend
);

   assign any_pend = |pend;

endmodule

// File: rtl/kcs_mbox.sv
module kcs_mbox
   import kcs_mbox_pkg::*;
#(
   parameter int          NUM_CH    = 4,
   parameter int          AW        = 10,
   parameter int          DW        = 32,
   parameter int          NUM_WORDS = 72,
   parameter logic [31:0] STRAP_VAL = 32'h0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr_en,
   input  logic                  reg_rd_en,
   input  logic [AW-1:0]         reg_addr,
   input  logic [DW-1:0]         reg_wdata,
   output logic [DW-1:0]         reg_rdata,
   input  logic [NUM_CH-1:0]     host_in_wr,
   input  logic [NUM_CH*8-1:0]   host_in_byte,
   input  logic [NUM_CH-1:0]     host_out_rd,
   input  logic [NUM_CH-1:0]     host_stat_wr,
   output logic [NUM_CH*8-1:0]   host_out_byte,
   output logic [NUM_CH*8-1:0]   host_stat,
   output logic [NUM_CH-1:0]     chan_irq,
   output logic                  summary_irq
);

   localparam int IDX_W = $clog2(NUM_WORDS);

   if (NUM_CH < 1 || NUM_CH > CH_MAX) begin : g_bad_ch
      $error("kcs_mbox: NUM_CH must be 1..4");
   end
   if (NUM_WORDS <= LAST_WORD) begin : g_bad_words
      $error("kcs_mbox: NUM_WORDS must cover word 71");
   end
   if ((1 << AW) < NUM_WORDS) begin : g_bad_aw
      $error("kcs_mbox: AW too small for NUM_WORDS");
   end
   if (DW < 8) begin : g_bad_dw
      $error("kcs_mbox: DW must be at least 8");
   end

   logic [DW-1:0]     regs_q [NUM_WORDS];
   logic              in_range;
   logic [IDX_W-1:0]  word;
   logic [NUM_CH-1:0] ch_hit;
   logic [DW-1:0]     ch_rdata [NUM_CH];
   logic [NUM_CH-1:0] irq_ok;
   logic              any_hit;
   logic [DW-1:0]     ch_rd_or;

   assign in_range = (int'(reg_addr) < NUM_WORDS);
   assign word     = reg_addr[IDX_W-1:0];

   always_comb begin
      any_hit  = 1'b0;
      ch_rd_or = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         any_hit  = any_hit | ch_hit[c];
         ch_rd_or = ch_rd_or | ch_rdata[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WORDS; i++)
            regs_q[i] <= (i == W_STRAP) ? DW'(STRAP_VAL) : '0;
      end else if (reg_wr_en && in_range && !any_hit) begin
         regs_q[word] <= reg_wdata;
      end
   end

   always_comb begin
      if (!in_range)    reg_rdata = '0;
      else if (any_hit) reg_rdata = ch_rd_or;
      else              reg_rdata = regs_q[word];
   end

   kcs_mbox_enmap #(.NUM_CH(NUM_CH), .DW(DW)) u_enmap (
      .hostctl0 (regs_q[W_HOSTCTL0]),
      .irqctl   (regs_q[W_IRQCTL]),
      .hostctl4 (regs_q[W_HOSTCTL4]),
      .ch3ctl   (regs_q[W_CH3CTL]),
      .irq_ok   (irq_ok)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      kcs_mbox_chan #(.CH(c), .AW(AW), .DW(DW)) u_chan (
         .clk          (clk),
         .rst_n        (rst_n),
         .bus_wr       (reg_wr_en),
         .bus_rd       (reg_rd_en),
         .bus_idx      (reg_addr),
         .bus_wdata    (reg_wdata),
         .host_wr      (host_in_wr[c]),
         .host_wbyte   (host_in_byte[c*8 +: 8]),
         .host_rd      (host_out_rd[c]),
         .host_stat_wr (host_stat_wr[c]),
         .irq_ok       (irq_ok[c]),
         .hit          (ch_hit[c]),
         .rdata        (ch_rdata[c]),
         .out_byte     (host_out_byte[c*8 +: 8]),
         .stat_byte    (host_stat[c*8 +: 8]),
         .irq_q        (chan_irq[c])
      );
   end

   kcs_mbox_irqor #(.NUM_CH(NUM_CH)) u_irqor (
      .pend     (chan_irq),
      .any_pend (summary_irq)
   );

   assert_strap_load_R1: assert property (@(posedge clk)
      $fell(rst_n) |=> (regs_q[W_STRAP] == DW'(STRAP_VAL)));

   assert_far_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !in_range) |=> $stable(regs_q[W_HOSTCTL0]));

endmodule

// File: tb/kcs_mbox_tb.sv
module kcs_mbox_tb;

   localparam logic [31:0] STRAP = 32'h0000_A5C3;

   typedef struct packed {
      logic [9:0]  idx;
      logic [31:0] wd;
      logic [31:0] exp;
   } vec_t;

   // R2 storage, R9 out-of-range, R12 status write, R1 strap overwrite
   localparam vec_t VECS [8] = '{
      '{10'd0,    32'h1234_5678, 32'h1234_5678},
      '{10'd2,    32'hCAFE_0001, 32'hCAFE_0001},
      '{10'd20,   32'hDEAD_BEEF, 32'hDEAD_BEEF},
      '{10'd34,   32'h0000_0055, 32'h0000_0055},
      '{10'd64,   32'h8000_0002, 32'h8000_0002},
      '{10'd15,   32'h0000_0009, 32'h0000_0009},
      '{10'd72,   32'hFFFF_FFFF, 32'h0000_0000},
      '{10'd1023, 32'hA5A5_A5A5, 32'h0000_0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  host_in_wr = '0, host_out_rd = '0, host_stat_wr = '0;
   logic [31:0] host_in_byte = '0;
   logic [31:0] host_out_byte, host_stat;
   logic [3:0]  chan_irq;
   logic        summary_irq;

   int n_chk = 0, n_bad = 0;
   logic [31:0] rd;

   always #4 clk = ~clk;

   kcs_mbox #(.STRAP_VAL(STRAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .host_in_wr(host_in_wr), .host_in_byte(host_in_byte), .host_out_rd(host_out_rd),
      .host_stat_wr(host_stat_wr), .host_out_byte(host_out_byte), .host_stat(host_stat),
      .chan_irq(chan_irq), .summary_irq(summary_irq)
   );

   function automatic int in_idx(input int ch);
      case (ch) 0: return 9; 1: return 10; 2: return 11; default: return 69; endcase
   endfunction
   function automatic int out_idx(input int ch);
      case (ch) 0: return 12; 1: return 13; 2: return 14; default: return 70; endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = 10'(idx); reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic bus_read(input int idx, output logic [31:0] d);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_addr = 10'(idx);
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd_en = 1'b0;
   endtask

   task automatic host_write(input int ch, input logic [7:0] b);
      @(negedge clk);
      host_in_wr[ch] = 1'b1; host_in_byte[ch*8 +: 8] = b;
      @(negedge clk);
      host_in_wr[ch] = 1'b0;
   endtask

   task automatic host_read(input int ch);
      @(negedge clk);
      host_out_rd[ch] = 1'b1;
      @(negedge clk);
      host_out_rd[ch] = 1'b0;
   endtask

   function automatic logic [31:0] sbyte(input int ch);
      return {24'h0, host_stat[ch*8 +: 8]};
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      do_reset();
      // R1 reset state
      bus_read(0, rd);  check("R1 word0", rd, 32'h0);
      bus_read(15, rd); check("R1 status ch0", rd, 32'h0);
      bus_read(34, rd); check("R1 strap", rd, STRAP);
      check("R1 irqs", {27'h0, summary_irq, chan_irq}, 32'h0);

      // table walk: R2 storage, R9, R12
      foreach (VECS[i]) begin
         bus_write(int'(VECS[i].idx), VECS[i].wd);
         bus_read(int'(VECS[i].idx), rd);
         check($sformatf("R2/R9/R12 vec %0d", i), rd, VECS[i].exp);
      end
      check("R12 host status byte", sbyte(0), 32'h09);
      bus_read(8, rd); check("R9 no alias", rd, 32'h0);

      // full handshake per channel: R3 R4 R5 R6 R10
      do_reset();
      bus_write(0, 32'hE0); bus_write(4, 32'h04); bus_write(2, 32'h0E); bus_write(64, 32'h03);
      for (int ch = 0; ch < 4; ch++) begin
         host_write(ch, 8'h30 + 8'(ch));
         check($sformatf("R3 ibf ch%0d", ch), sbyte(ch), 32'h02);
         check($sformatf("R6 irq ch%0d", ch), {31'h0, chan_irq[ch]}, 32'h1);
         check($sformatf("R10 summary ch%0d", ch), {31'h0, summary_irq}, 32'h1);
         bus_read(in_idx(ch), rd);
         check($sformatf("R4 data ch%0d", ch), rd, 32'h30 + ch);
         check($sformatf("R4 ibf clr ch%0d", ch), sbyte(ch), 32'h0);
         check($sformatf("R4 irq low ch%0d", ch), {31'h0, chan_irq[ch]}, 32'h0);
         bus_write(out_idx(ch), 32'h5A + ch);
         check($sformatf("R5 out byte ch%0d", ch), {24'h0, host_out_byte[ch*8 +: 8]}, 32'h5A + ch);
         check($sformatf("R5 obf ch%0d", ch), sbyte(ch), 32'h01);
         host_read(ch);
         check($sformatf("R5 obf clr ch%0d", ch), sbyte(ch), 32'h0);
      end

      // R6: interrupt enables set but channels off
      do_reset();
      bus_write(2, 32'h0E); bus_write(64, 32'h02);
      host_write(0, 8'h11);
      host_write(3, 8'h22);
      check("R6 ibf while off", sbyte(0), 32'h02);
      check("R6 no irq while off", {28'h0, chan_irq}, 32'h0);
      // enabled but interrupt enable clear
      bus_write(0, 32'h40);
      bus_write(2, 32'h0);
      host_write(1, 8'h33);
      check("R6 no irq without ie", {28'h0, chan_irq}, 32'h0);

      // R7: channel 2 needs both enables
      do_reset();
      bus_write(0, 32'h80); bus_write(2, 32'h08);
      host_write(2, 8'h44);
      check("R7 single enable", {31'h0, chan_irq[2]}, 32'h0);
      bus_read(11, rd);
      bus_write(4, 32'h04);
      host_write(2, 8'h45);
      check("R7 both enables", {31'h0, chan_irq[2]}, 32'h1);

      // R8: host status write ignored
      bus_write(13, 32'h77);
      check("R8 before", sbyte(1), 32'h01);
      @(negedge clk); host_stat_wr[1] = 1'b1;
      @(negedge clk); host_stat_wr[1] = 1'b0;
      check("R8 status unchanged", sbyte(1), 32'h01);

      // R11 collisions on channel 0
      do_reset();
      bus_write(0, 32'h20); bus_write(2, 32'h02);
      host_write(0, 8'hA1);
      @(negedge clk);
      reg_rd_en = 1'b1; reg_addr = 10'd9;
      host_in_wr[0] = 1'b1; host_in_byte[7:0] = 8'hB2;
      #1 rd = reg_rdata;
      @(negedge clk);
      reg_rd_en = 1'b0; host_in_wr[0] = 1'b0;
      check("R11 read old data", rd, 32'hA1);
      check("R11 ibf kept", sbyte(0), 32'h02);
      check("R11 irq kept", {31'h0, chan_irq[0]}, 32'h1);
      bus_read(9, rd);
      check("R11 new data", rd, 32'hB2);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = 10'd12; reg_wdata = 32'hC3;
      host_out_rd[0] = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; host_out_rd[0] = 1'b0;
      check("R11 obf cleared", sbyte(0), 32'h0);
      check("R11 out stored", {24'h0, host_out_byte[7:0]}, 32'hC3);

      // R10: summary across two channels
      do_reset();
      bus_write(0, 32'h60); bus_write(2, 32'h06);
      host_write(0, 8'h01);
      host_write(1, 8'h02);
      bus_read(9, rd);
      check("R10 one left", {30'h0, summary_irq, chan_irq[1]}, 32'h3);
      bus_read(10, rd);
      check("R10 none left", {31'h0, summary_irq}, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule